// File: doc/BRIEF.md
# Conditional execution gate

This block decides, for every instruction leaving decode, whether its 4-bit predicate holds against the current negative, zero, carry and overflow flags. The predicate field sits in the top nibble of the instruction word; the gate takes that nibble directly. A single `pass` output reports the result. When `pass` is low, the instruction must retire as a no-op, so the gate also masks each side effect the instruction asked for: register-file write requests, the branch request and the flag update.

The flag update is enabled only when the instruction's set-flags bit is high and the predicate holds. A predicated flag-setting instruction that fails therefore leaves the flags untouched. The gate is purely combinational, with no storage and no clock. It sits between decode and writeback, and all of its outputs settle in the same cycle as its inputs. The number of register write lanes is a parameter.

Predicate codes, in binary, and their pass conditions: 0000 zero set; 0001 zero clear; 0010 carry set (unsigned higher-or-same); 0011 carry clear (unsigned lower); 0100 negative set; 0101 negative clear; 0110 overflow set; 0111 overflow clear; 1000 carry set and zero clear (unsigned higher); 1001 carry clear or zero set (unsigned lower-or-same); 1010 negative equals overflow (signed ≥); 1011 negative differs from overflow (signed <); 1100 zero clear and negative equals overflow (signed >); 1101 zero set or negative differs from overflow (signed ≤); 1110 always; 1111 never.

Top module: `cond_exec_gate`

## Requirements
- R1: Code 0000 passes exactly when Z=1, and code 0001 passes exactly when Z=0.
- R2: Code 0010 passes exactly when C=1, and code 0011 passes exactly when C=0.
- R3: Code 0100 passes exactly when N=1, and code 0101 passes exactly when N=0.
- R4: Code 0110 passes exactly when V=1, and code 0111 passes exactly when V=0.
- R5: Code 1000 passes exactly when C=1 and Z=0, and code 1001 passes exactly when C=0 or Z=1.
- R6: Code 1010 passes exactly when N equals V, and code 1011 passes exactly when N differs from V.
- R7: Code 1100 passes exactly when Z=0 and N equals V, and code 1101 passes exactly when Z=1 or N differs from V.
- R8: Code 1110 passes for every flag value, and code 1111 never passes.
- R9: `flag_wr_en` is high exactly when `set_flags` is high and `pass` is high, so a failing predicate suppresses the flag update.
- R10: Each bit of `reg_wr_en` equals the matching bit of `reg_wr_req` AND `pass`.
- R11: `branch_en` equals `branch_req` AND `pass`.
- R12: The block holds no state. Every output reflects the present inputs within the same cycle, and a change of inputs within a cycle is seen at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cond_code | input | 4 | Predicate field taken from the instruction's top nibble |
| flag_n | input | 1 | Current negative flag |
| flag_z | input | 1 | Current zero flag |
| flag_c | input | 1 | Current carry flag |
| flag_v | input | 1 | Current overflow flag |
| set_flags | input | 1 | The instruction asks to update the flags |
| reg_wr_req | input | NUM_WR | Register write requests from decode, one per lane |
| branch_req | input | 1 | The instruction asks to change the program counter |
| pass | output | 1 | Predicate holds for the current flags |
| flag_wr_en | output | 1 | Final flag-write enable |
| reg_wr_en | output | NUM_WR | Gated register write enables |
| branch_en | output | 1 | Gated branch enable |

## Verification
The checker's immediate assertions assume only that every input carries a defined 0 or 1. The predicate and flag nibbles are used as given, so no code value and no flag combination is excluded. The stimulus is driven only from the bench, shortly after each clock edge, and it sweeps all sixteen codes against all sixteen flag combinations and every pattern of the request inputs. No input is ever left undriven or unknown. Because the gate is combinational, each pattern has settled well before the opposite clock edge, where it is sampled.

// File: rtl/cexg_pkg.sv
`timescale 1ns/1ps
package cexg_pkg;
   localparam int COND_W  = 4;
   localparam int N_BASE  = 1 << (COND_W - 1);

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } flags_t;

   typedef enum logic [COND_W-1:0] {
      PR_ZS  = 4'b0000,
      PR_ZC  = 4'b0001,
      PR_CS  = 4'b0010,
      PR_CC  = 4'b0011,
      PR_NS  = 4'b0100,
      PR_NC  = 4'b0101,
      PR_VS  = 4'b0110,
      PR_VC  = 4'b0111,
      PR_UGT = 4'b1000,
      PR_ULE = 4'b1001,
      PR_SGE = 4'b1010,
      PR_SLT = 4'b1011,
      PR_SGT = 4'b1100,
      PR_SLE = 4'b1101,
      PR_ANY = 4'b1110,
      PR_NON = 4'b1111
   } pred_e;
endpackage

// File: rtl/cexg_pred_bank.sv
`timescale 1ns/1ps
// Computes the eight base predicates; odd codes are their complements.
module cexg_pred_bank
   import cexg_pkg::*;
(
   input  flags_t              flg,
   output logic [N_BASE-1:0]   base
);
   logic sign_ok;
   always_comb begin
      sign_ok = (flg.n == flg.v);
      base    = '0;
      base[0] = flg.z;
      base[1] = flg.c;
      base[2] = flg.n;
      base[3] = flg.v;
      base[4] = flg.c & ~flg.z;
      base[5] = sign_ok;
      base[6] = ~flg.z & sign_ok;
      base[7] = 1'b1;
   end
endmodule

// File: rtl/cexg_cond_sel.sv
`timescale 1ns/1ps
// Picks one base predicate by the upper code bits, inverts by the low bit.
module cexg_cond_sel
   import cexg_pkg::*;
(
   input  logic [COND_W-1:0]   code,
   input  logic [N_BASE-1:0]   base,
   output logic                hit
);
   localparam int IDX_W = COND_W - 1;
   logic [IDX_W-1:0] idx;
   logic             raw;
   always_comb begin
      idx = code[COND_W-1:1];
      raw = base[idx];
      hit = raw ^ code[0];
   end
endmodule

// File: rtl/cexg_effect_gate.sv
`timescale 1ns/1ps
// Masks every side effect of the instruction with the predicate result.
module cexg_effect_gate #(
   parameter int NUM_WR = 2
) (
   input  logic              hit,
   input  logic              set_flags,
   input  logic [NUM_WR-1:0] wr_req,
   input  logic              br_req,
   output logic              flg_en,
   output logic [NUM_WR-1:0] wr_en,
   output logic              br_en
);
   for (genvar i = 0; i < NUM_WR; i++) begin : g_lane
      assign wr_en[i] = wr_req[i] & hit;
   end
   assign flg_en = set_flags & hit;
   assign br_en  = br_req & hit;
endmodule

// File: rtl/cond_exec_gate.sv
`timescale 1ns/1ps
module cond_exec_gate
   import cexg_pkg::*;
#(
   parameter int NUM_WR = 2
) (
   input  logic [3:0]        cond_code,
   input  logic              flag_n,
   input  logic              flag_z,
   input  logic              flag_c,
   input  logic              flag_v,
   input  logic              set_flags,
   input  logic [NUM_WR-1:0] reg_wr_req,
   input  logic              branch_req,
   output logic              pass,
   output logic              flag_wr_en,
   output logic [NUM_WR-1:0] reg_wr_en,
   output logic              branch_en
);
   if (NUM_WR < 1 || NUM_WR > 16) begin : g_bad_lanes
      $error("cond_exec_gate: NUM_WR must lie in 1..16");
   end

   flags_t              flg;
   logic [N_BASE-1:0]   base;

   assign flg = '{n: flag_n, z: flag_z, c: flag_c, v: flag_v};

   cexg_pred_bank u_bank (
      .flg  (flg),
      .base (base)
   );

   cexg_cond_sel u_sel (
      .code (cond_code),
      .base (base),
      .hit  (pass)
   );

   cexg_effect_gate #(.NUM_WR(NUM_WR)) u_gate (
      .hit       (pass),
      .set_flags (set_flags),
      .wr_req    (reg_wr_req),
      .br_req    (branch_req),
      .flg_en    (flag_wr_en),
      .wr_en     (reg_wr_en),
      .br_en     (branch_en)
   );
endmodule

// File: rtl/cond_exec_gate_chk.sv
`timescale 1ns/1ps
module cond_exec_gate_chk #(
   parameter int NUM_WR = 2
) (
   input logic [3:0]        cond_code,
   input logic              flag_n,
   input logic              flag_z,
   input logic              flag_c,
   input logic              flag_v,
   input logic              set_flags,
   input logic [NUM_WR-1:0] reg_wr_req,
   input logic              branch_req,
   input logic              pass,
   input logic              flag_wr_en,
   input logic [NUM_WR-1:0] reg_wr_en,
   input logic              branch_en
);
   always_comb begin
      if (cond_code == 4'b0000) a_r1_zero_set: assert (pass == flag_z);
      if (cond_code == 4'b0011) a_r2_carry_clear: assert (pass == !flag_c);
      if (cond_code == 4'b0101) a_r3_neg_clear: assert (pass == !flag_n);
      if (cond_code == 4'b0110) a_r4_ovf_set: assert (pass == flag_v);
      if (cond_code == 4'b1000 && flag_z) a_r5_higher_needs_nz: assert (!pass);
      if (cond_code == 4'b1011) a_r6_signed_less: assert (pass == (flag_n != flag_v));
      if (cond_code == 4'b1100 && flag_z) a_r7_greater_needs_nz: assert (!pass);
      if (cond_code == 4'b1110) a_r8_always: assert (pass);
      if (cond_code == 4'b1111) a_r8_never: assert (!pass);
      a_r9_flags_need_sbit: assert (!flag_wr_en || (set_flags && pass));
      a_r10_no_spurious_wr: assert ((reg_wr_en & ~reg_wr_req) == '0);
      if (!pass) a_r10_squash_wr: assert (reg_wr_en == '0);
      a_r11_branch_gate: assert (branch_en == (branch_req && pass));
   end
endmodule

bind cond_exec_gate cond_exec_gate_chk #(.NUM_WR(NUM_WR)) u_chk (.*);

// File: tb/cond_exec_gate_bench.sv
`timescale 1ns/1ps
module cond_exec_gate_bench;
   localparam int NW = 2;

   logic          clk = 1'b0;
   logic [3:0]    cond_code = '0;
   logic          flag_n = 0, flag_z = 0, flag_c = 0, flag_v = 0;
   logic          set_flags = 0, branch_req = 0;
   logic [NW-1:0] reg_wr_req = '0;
   logic          pass, flag_wr_en, branch_en;
   logic [NW-1:0] reg_wr_en;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   cond_exec_gate #(.NUM_WR(NW)) u_cond_exec_gate (
      .cond_code(cond_code), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
      .flag_v(flag_v), .set_flags(set_flags), .reg_wr_req(reg_wr_req),
      .branch_req(branch_req), .pass(pass), .flag_wr_en(flag_wr_en),
      .reg_wr_en(reg_wr_en), .branch_en(branch_en)
   );

   function automatic bit ref_pass(int c, bit n, bit z, bit cy, bit v);
      case (c)
         0:  return z;
         1:  return !z;
         2:  return cy;
         3:  return !cy;
         4:  return n;
         5:  return !n;
         6:  return v;
         7:  return !v;
         8:  return cy && !z;
         9:  return !cy || z;
         10: return n == v;
         11: return n != v;
         12: return !z && (n == v);
         13: return z || (n != v);
         14: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic string ref_tag(int c);
      case (c / 2)
         0: return "R1";
         1: return "R2";
         2: return "R3";
         3: return "R4";
         4: return "R5";
         5: return "R6";
         6: return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic check(string tag, int act, int exp, string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d (code=%0d nzcv=%b%b%b%b)",
                  tag, what, act, exp, cond_code, flag_n, flag_z, flag_c, flag_v);
      end
   endtask

   task automatic compare_all();
      bit p;
      p = ref_pass(int'(cond_code), flag_n, flag_z, flag_c, flag_v);
      check(ref_tag(int'(cond_code)), int'(pass), int'(p), "pass");
      check("R9", int'(flag_wr_en), int'(set_flags && p), "flag_wr_en");
      check("R10", int'(reg_wr_en), p ? int'(reg_wr_req) : 0, "reg_wr_en");
      check("R11", int'(branch_en), int'(branch_req && p), "branch_en");
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected<%0d cycles", cycles, 150000);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // Reset state: all inputs low, code 0000 with Z=0 fails, nothing enabled.
      @(negedge clk);
      check("R1", int'(pass), 0, "reset pass");
      check("R9", int'(flag_wr_en), 0, "reset flag_wr_en");
      check("R10", int'(reg_wr_en), 0, "reset reg_wr_en");
      check("R11", int'(branch_en), 0, "reset branch_en");

      // Exhaustive sweep: codes R1..R8, gating R9..R11.
      for (int c = 0; c < 16; c++) begin
         for (int f = 0; f < 16; f++) begin
            for (int g = 0; g < 16; g++) begin
               @(posedge clk);
               #1;
               cond_code  = 4'(c);
               {flag_n, flag_z, flag_c, flag_v} = 4'(f);
               set_flags  = g[0];
               reg_wr_req = NW'(g >> 1);
               branch_req = g[3];
               @(negedge clk);
               compare_all();
            end
         end
      end

      // R12: inputs changed twice inside one cycle are reflected immediately.
      @(posedge clk);
      #0.5;
      cond_code = 4'b1110; set_flags = 1; reg_wr_req = '1; branch_req = 1;
      #0.5;
      check("R12", int'(pass), 1, "mid-cycle pass (always)");
      check("R12", int'(flag_wr_en), 1, "mid-cycle flag_wr_en");
      cond_code = 4'b1111;
      #0.5;
      check("R12", int'(pass), 0, "mid-cycle pass (never)");
      check("R12", int'(reg_wr_en), 0, "mid-cycle reg_wr_en");
      check("R12", int'(branch_en), 0, "mid-cycle branch_en");

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule